// File: doc/BRIEF.md
# Masked Packed-Element Rotate Unit

This block rotates every element of a 128-bit packed data word to the right in a single pass. The element width can be 8, 16, 32, 64 or 128 bits. Each element's rotate amount comes from one of six sources. It can be a count word read at the data element width, or a count word read as fixed 8-, 16- or 32-bit slots whatever the data width. It can also be one scalar count shared by all elements, or an immediate shared by all elements. Only the low log2(width) bits of any count matter, so a count at or above the width wraps around.

A per-element mask chooses which elements take the rotated value. An element whose mask bit is clear keeps the old destination value, which the unit receives as an input. The merged word is registered, and a valid flag follows the input valid by one clock. A wrapper that owns decode and register grouping drives one slice per issue.

Top module: `simd_rot_unit`

## Requirements
- R1: For an element of width W and effective amount a, bit b of the result equals bit (b + a) mod W of the source element (rotate right). The effective amount is the count modulo W, so a count of W or more wraps around.
- R2: Mask bit i governs element i, and only the low 128/W mask bits are used. An element whose mask bit is 0 takes the old destination element unchanged and is never zeroed.
- R3: width_sel codes 0..4 select element widths 8, 16, 32, 64 and 128. Codes 5..7 make the result equal the old destination word.
- R4: When cnt_src is 0, element i takes its count from element i of cnt_vec, read at the data element width.
- R5: When cnt_src is 1, 2 or 3, element i takes its count from slot i of cnt_vec, with slots 8, 16 or 32 bits wide. An element whose slot lies beyond bit 127 uses count 0. Slots past the last data element are ignored.
- R6: When cnt_src is 4, every element uses scalar_cnt as its count.
- R7: When cnt_src is 5, every element uses imm_cnt AND 0x7F as its count. Codes 6 and 7 use count 0.
- R8: out_valid is in_valid delayed by one clock. result is loaded only in a cycle with in_valid high and otherwise holds.
- R9: While reset is active, and until reset has been released, out_valid is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| width_sel | input | 3 | Element width code (0..4 = 8..128 bits) |
| cnt_src | input | 3 | Count source code (0 same width, 1/2/3 8/16/32-bit slots, 4 scalar, 5 immediate) |
| src_vec | input | 128 | Data word to rotate |
| cnt_vec | input | 128 | Count vector operand |
| scalar_cnt | input | 64 | Shared scalar count |
| imm_cnt | input | 8 | Immediate count, bit 7 ignored |
| mask | input | 16 | Per-element enable, low 128/W bits used |
| old_dst | input | 128 | Previous destination word |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Merged rotated word |

## Verification
The rotate and the mask merge act in the same cycle on neighbouring elements of one word. A random mask together with counts of 0, W-1, W and values above W therefore puts rotated, wrapped and held elements side by side. The bench sweeps every width against every count source in this way. Each result is judged against a behavioural model that rebuilds each bit from modulo arithmetic. Directed words cover the narrow-slot overflow, where out-of-range slots fall together with in-range ones, and also high mask bits, which must be ignored.

// File: rtl/simd_rot_pkg.sv
package simd_rot_pkg;
  typedef enum logic [2:0] {
    EW_8   = 3'd0,
    EW_16  = 3'd1,
    EW_32  = 3'd2,
    EW_64  = 3'd3,
    EW_128 = 3'd4
  } ew_sel_e;

  typedef enum logic [2:0] {
    CS_SAME   = 3'd0,
    CS_VEC8   = 3'd1,
    CS_VEC16  = 3'd2,
    CS_VEC32  = 3'd3,
    CS_SCALAR = 3'd4,
    CS_IMM    = 3'd5
  } cnt_src_e;

  localparam int NUM_EW  = 5;
  localparam int MIN_EW  = 8;
endpackage

// File: rtl/simd_rot_count_pick.sv
module simd_rot_count_pick
  import simd_rot_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  parameter int EW   = 8,
  parameter int IDX  = 0,
  localparam int AW  = $clog2(EW)
) (
  input  logic [2:0]      cnt_src,
  input  logic [VLEN-1:0] cnt_vec,
  input  logic [XLEN-1:0] scalar_cnt,
  input  logic [7:0]      imm_cnt,
  output logic [AW-1:0]   amt
);
  localparam bool_t_unused = 0;
  logic [AW-1:0] c_same, c_s8, c_s16, c_s32;
  logic          unused_pick;

  // Low AW bits of each slot are all the rotator needs (AW <= 7).
  assign c_same = cnt_vec[IDX*EW +: AW];

  generate
    if ((IDX + 1) * 8 <= VLEN) begin : g_s8
      assign c_s8 = cnt_vec[IDX*8 +: AW];
    end else begin : g_s8_off
      assign c_s8 = '0;
    end
    if ((IDX + 1) * 16 <= VLEN) begin : g_s16
      assign c_s16 = cnt_vec[IDX*16 +: AW];
    end else begin : g_s16_off
      assign c_s16 = '0;
    end
    if ((IDX + 1) * 32 <= VLEN) begin : g_s32
      assign c_s32 = cnt_vec[IDX*32 +: AW];
    end else begin : g_s32_off
      assign c_s32 = '0;
    end
  endgenerate

  always_comb begin
    case (cnt_src)
      CS_SAME:   amt = c_same;
      CS_VEC8:   amt = c_s8;
      CS_VEC16:  amt = c_s16;
      CS_VEC32:  amt = c_s32;
      CS_SCALAR: amt = scalar_cnt[AW-1:0];
      CS_IMM:    amt = imm_cnt[AW-1:0];  // bit 7 never reaches AW <= 7
      default:   amt = '0;
    endcase
  end

  assign unused_pick = ^{cnt_vec, scalar_cnt, imm_cnt};
endmodule

// File: rtl/simd_rot_lane.sv
module simd_rot_lane #(
  parameter int EW  = 8,
  localparam int AW = $clog2(EW)
) (
  input  logic [EW-1:0] elem,
  input  logic [EW-1:0] old_elem,
  input  logic [AW-1:0] amt,
  input  logic          en,
  output logic [EW-1:0] res
);
  logic [EW-1:0] rot_lo;

  assign rot_lo = EW'({elem, elem} >> amt);
  assign res    = en ? rot_lo : old_elem;
endmodule

// File: rtl/simd_rot_width_slice.sv
module simd_rot_width_slice #(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  parameter int EW   = 8,
  localparam int NE  = VLEN / EW,
  localparam int MW  = VLEN / 8,
  localparam int AW  = $clog2(EW)
) (
  input  logic [2:0]      cnt_src,
  input  logic [VLEN-1:0] src_vec,
  input  logic [VLEN-1:0] cnt_vec,
  input  logic [XLEN-1:0] scalar_cnt,
  input  logic [7:0]      imm_cnt,
  input  logic [MW-1:0]   mask,
  input  logic [VLEN-1:0] old_dst,
  output logic [VLEN-1:0] res
);
  logic unused_mask;

  generate
    for (genvar i = 0; i < NE; i++) begin : g_elem
      logic [AW-1:0] amt;

      simd_rot_count_pick #(
        .VLEN(VLEN), .XLEN(XLEN), .EW(EW), .IDX(i)
      ) u_pick (
        .cnt_src    (cnt_src),
        .cnt_vec    (cnt_vec),
        .scalar_cnt (scalar_cnt),
        .imm_cnt    (imm_cnt),
        .amt        (amt)
      );

      simd_rot_lane #(.EW(EW)) u_lane (
        .elem     (src_vec[i*EW +: EW]),
        .old_elem (old_dst[i*EW +: EW]),
        .amt      (amt),
        .en       (mask[i]),
        .res      (res[i*EW +: EW])
      );
    end
  endgenerate

  assign unused_mask = ^mask;
endmodule

// File: rtl/simd_rot_unit.sv
module simd_rot_unit
  import simd_rot_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  localparam int MW  = VLEN / MIN_EW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      width_sel,
  input  logic [2:0]      cnt_src,
  input  logic [VLEN-1:0] src_vec,
  input  logic [VLEN-1:0] cnt_vec,
  input  logic [XLEN-1:0] scalar_cnt,
  input  logic [7:0]      imm_cnt,
  input  logic [MW-1:0]   mask,
  input  logic [VLEN-1:0] old_dst,
  output logic            out_valid,
  output logic [VLEN-1:0] result
);
  logic [1:0]      rst_pipe;
  logic            rst_q;
  logic [VLEN-1:0] slice_res [NUM_EW];
  logic [VLEN-1:0] nxt_result;

  // Reset asserts at once, releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  generate
    for (genvar k = 0; k < NUM_EW; k++) begin : g_width
      simd_rot_width_slice #(
        .VLEN(VLEN), .XLEN(XLEN), .EW(MIN_EW << k)
      ) u_slice (
        .cnt_src    (cnt_src),
        .src_vec    (src_vec),
        .cnt_vec    (cnt_vec),
        .scalar_cnt (scalar_cnt),
        .imm_cnt    (imm_cnt),
        .mask       (mask),
        .old_dst    (old_dst),
        .res        (slice_res[k])
      );
    end
  endgenerate

  always_comb begin
    case (width_sel)
      EW_8:    nxt_result = slice_res[0];
      EW_16:   nxt_result = slice_res[1];
      EW_32:   nxt_result = slice_res[2];
      EW_64:   nxt_result = slice_res[3];
      EW_128:  nxt_result = slice_res[4];
      default: nxt_result = old_dst;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt_result;
    end
  end
endmodule

// File: rtl/simd_rot_unit_chk.sv
module simd_rot_unit_chk #(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  localparam int MW  = VLEN / 8
) (
  input logic            clk,
  input logic            rst_q,
  input logic            in_valid,
  input logic [2:0]      width_sel,
  input logic [2:0]      cnt_src,
  input logic [VLEN-1:0] src_vec,
  input logic [XLEN-1:0] scalar_cnt,
  input logic [7:0]      imm_cnt,
  input logic [MW-1:0]   mask,
  input logic [VLEN-1:0] old_dst,
  input logic            out_valid,
  input logic [VLEN-1:0] result
);
  logic unused_chk;
  assign unused_chk = ^{scalar_cnt, imm_cnt};

  assert_valid_lat_R8: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid == $past(in_valid));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(result));

  assert_mask_off_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && mask == '0) |=> result == $past(old_dst));

  assert_bad_width_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && width_sel > 3'd4) |=> result == $past(old_dst));

  assert_half_swap_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && width_sel == 3'd4 && cnt_src == 3'd4 && scalar_cnt[6:0] == 7'd64 && mask[0])
    |=> result[127:0] == {$past(src_vec[63:0]), $past(src_vec[127:64])});

  assert_imm_zero_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && cnt_src == 3'd5 && imm_cnt[6:0] == 7'd0 && (&mask) && width_sel < 3'd5)
    |=> result == $past(src_vec));
endmodule

bind simd_rot_unit simd_rot_unit_chk #(.VLEN(VLEN), .XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .in_valid   (in_valid),
  .width_sel  (width_sel),
  .cnt_src    (cnt_src),
  .src_vec    (src_vec),
  .scalar_cnt (scalar_cnt),
  .imm_cnt    (imm_cnt),
  .mask       (mask),
  .old_dst    (old_dst),
  .out_valid  (out_valid),
  .result     (result)
);

// File: tb/simd_rot_unit_tb.sv
`timescale 1ns/1ps
module simd_rot_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   width_sel, cnt_src;
  logic [127:0] src_vec, cnt_vec, old_dst;
  logic [63:0]  scalar_cnt;
  logic [7:0]   imm_cnt;
  logic [15:0]  mask;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  simd_rot_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_sel(width_sel),
    .cnt_src(cnt_src), .src_vec(src_vec), .cnt_vec(cnt_vec),
    .scalar_cnt(scalar_cnt), .imm_cnt(imm_cnt), .mask(mask),
    .old_dst(old_dst), .out_valid(out_valid), .result(result)
  );

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int cs);
    case (cs)
      0: return "R4";
      1, 2, 3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Behavioural model: each bit rebuilt from modulo arithmetic.
  function automatic logic [127:0] model(int w, int cs, logic [127:0] src,
      logic [127:0] cv, logic [63:0] sc, logic [7:0] imm, logic [15:0] msk,
      logic [127:0] old);
    logic [127:0] r = old;
    int ew, ne, amt, cw;
    if (w > 4) return old;
    ew = 8 << w;
    ne = 128 / ew;
    for (int e = 0; e < ne; e++) begin
      amt = 0;
      case (cs)
        0: amt = int'((cv >> (e * ew)) & 128'(ew - 1));
        1, 2, 3: begin
          cw = 8 << (cs - 1);
          if ((e + 1) * cw <= 128) amt = int'((cv >> (e * cw)) & 128'(ew - 1));
        end
        4: amt = int'(sc % 64'(ew));
        5: amt = int'(imm & 8'h7F) % ew;
        default: amt = 0;
      endcase
      if (msk[e])
        for (int b = 0; b < ew; b++)
          r[e * ew + b] = src[e * ew + (b + amt) % ew];
    end
    return r;
  endfunction

  task automatic issue(int w, int cs, logic [127:0] s, logic [127:0] cv,
      logic [63:0] sc, logic [7:0] im, logic [15:0] m, logic [127:0] od);
    width_sel = 3'(w); cnt_src = 3'(cs); src_vec = s; cnt_vec = cv;
    scalar_cnt = sc; imm_cnt = im; mask = m; old_dst = od; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] s, cv, od, exp, held;
    logic [63:0]  sc;
    logic [7:0]   im;
    logic [15:0]  m;
    rst_n = 1'b0; in_valid = 1'b0; width_sel = '0; cnt_src = '0;
    src_vec = '0; cnt_vec = '0; scalar_cnt = '0; imm_cnt = '0; mask = '0; old_dst = '0;
    repeat (3) @(negedge clk);
    check("R9 valid", 128'(out_valid), 128'd0);
    check("R9 result", result, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 after release", 128'(out_valid), 128'd0);

    // R1: 32-bit rotate, count 33 wraps to 1
    issue(2, 0, {4{32'h8000_0001}}, {4{32'd33}}, 64'd0, 8'd0, 16'h000F, '0);
    check("R1 wrap", result, {4{32'hC000_0000}});
    check("R8 valid", 128'(out_valid), 128'd1);
    held = result;
    width_sel = 3'd0; src_vec = rnd128(); mask = 16'hFFFF;
    @(negedge clk);
    check("R8 no valid", 128'(out_valid), 128'd0);
    check("R8 hold", result, held);

    // R1: 128-bit scalar 64 swaps halves
    s = rnd128();
    issue(4, 4, s, '0, 64'd64, 8'd0, 16'h0001, '0);
    check("R1 half swap", result, {s[63:0], s[127:64]});

    // R2: mask zero keeps old; high mask bits ignored at 128-bit width
    s = rnd128(); od = rnd128();
    issue(0, 4, s, '0, 64'd3, 8'd0, 16'h0000, od);
    check("R2 mask zero", result, od);
    issue(4, 4, s, '0, 64'd5, 8'd0, 16'hFFFE, od);
    check("R2 high mask ignored", result, od);

    // R3: invalid width code
    issue(6, 0, s, rnd128(), 64'd1, 8'd1, 16'hFFFF, od);
    check("R3 bad width", result, od);

    // R5: 32-bit slots with 8-bit data, slots 4..15 absent
    cv = {4{32'h0101_0101}};
    issue(0, 3, s, cv, 64'd0, 8'd0, 16'hFFFF, od);
    exp = model(0, 3, s, cv, 64'd0, 8'd0, 16'hFFFF, od);
    check("R5 slot overflow", result, exp);
    check("R5 upper unrotated", result[127:32], s[127:32]);

    // R7: bit 7 of imm ignored, codes 6/7 give count 0
    issue(1, 5, s, '0, 64'd0, 8'h83, 16'hFFFF, od);
    check("R7 imm mask", result, model(1, 5, s, '0, 64'd0, 8'h03, 16'hFFFF, od));
    issue(1, 7, s, rnd128(), 64'd9, 8'd9, 16'hFFFF, od);
    check("R7 code 7", result, s);

    // Sweep: every width and source, special and random counts
    for (int w = 0; w < 5; w++) begin
      for (int cs = 0; cs < 6; cs++) begin
        for (int k = 0; k < 6; k++) begin
          int ew = 8 << w;
          int cw = (cs == 0) ? ew : (cs <= 3 ? (8 << (cs - 1)) : 8);
          int sv;
          case (k)
            0: sv = 0;
            1: sv = ew - 1;
            2: sv = ew;
            3: sv = ew + 1 + int'($urandom % 100);
            default: sv = int'($urandom % 256);
          endcase
          if (k < 4) begin
            cv = '0;
            for (int sl = 0; sl < 128 / cw; sl++) cv |= (128'(sv) << (sl * cw));
          end else cv = rnd128();
          s = rnd128(); od = rnd128(); m = 16'($urandom);
          sc = (k < 4) ? 64'(sv) : {$urandom, $urandom};
          im = 8'(sv) | (8'($urandom) & 8'h80);
          issue(w, cs, s, cv, sc, im, m, od);
          exp = model(w, cs, s, cv, sc, im, m, od);
          check({tag_of(cs), " R1 R2 sweep"}, result, exp);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule